// File: doc/BRIEF.md
# Receive Line Alarm Event Register

This block gathers alarm activity from the receive side of a DS3 line framer into one 8-bit register of sticky event flags. Two inputs are single-cycle error strobes: a CP-bit parity error and a P-bit parity error. Six inputs are level conditions: loss of signal, alarm indication signal, idle, far-end receive failure, AIC and out-of-frame. For each level input the register records a transition in either direction. The flag is raised when the condition begins and again when it ends.

A processor reads the register through a plain strobe-and-address port. The read returns every flag that has collected since the previous read and clears them all in the same clock. If a new event lands in the clock that performs the clear, that event is kept for the next read. A separate per-bit enable mask decides which flags drive the interrupt request. The mask has no effect on what is latched.

Top module: `rx_alarm_irq_reg`

## Requirements
- R1: A read at address 0x11 returns the flags in this order from bit 7 down to bit 0: CP-bit error, loss of signal, alarm indication, idle, far-end receive failure, AIC, out-of-frame, P-bit error.
- R2: While reset is low, and after reset is released, all flags read as 0, `rd_data` is 0 and `irq` is 0.
- R3: A high level on `cpbit_err_pulse` or `pbit_err_pulse` at a rising clock edge sets its flag at that edge. The flag stays set until a read.
- R4: A level input that differs from its value at the previous clock edge sets its flag at the current edge. This applies to both 0-to-1 and 1-to-0 transitions. The delayed copy resets to 0, so a level that is already high when reset releases counts as an onset.
- R5: When `rd_en` is high at an edge with address 0x11, `rd_data` holds the pre-edge flags from that edge onward, and every flag clears at the same edge.
- R6: A set event at the same edge as a clearing read leaves that flag at 1 after the read. The data returned by that read does not include the new event.
- R7: A read at any other address, and any edge without a read, gives `rd_data` = 0 and clears no flag.
- R8: `irq` is 1 exactly when some flag is set and its bit in `irq_mask` is 1. The mask does not change latching.
- R9: Without a read, flags never drop. A level held steady produces no further set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpbit_err_pulse | input | 1 | One-cycle CP-bit error strobe |
| pbit_err_pulse | input | 1 | One-cycle P-bit error strobe |
| los_lvl | input | 1 | Loss-of-signal condition level |
| ais_lvl | input | 1 | Alarm indication condition level |
| idle_lvl | input | 1 | Idle condition level |
| ferf_lvl | input | 1 | Far-end receive failure level (all X-bits 0) |
| aic_lvl | input | 1 | AIC condition level |
| oof_lvl | input | 1 | Out-of-frame condition level |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read address |
| irq_mask | input | 8 | Per-flag interrupt enable, same bit order as R1 |
| rd_data | output | 8 | Registered read result |
| irq | output | 1 | Interrupt request |

## Verification
The critical coincidence is a new set event arriving in the same clock as the clearing read. The bench provokes it with a P-bit strobe during a read. It also provokes it with a loss-of-signal level falling during a read of a flag that the rising edge of the same level had already set. The check passes when the returned data excludes the new event and the following read shows the flag still set, then cleared. A second pairing is a mask change in the same cycle as latching. There the bench judges that `irq` follows the mask while the later read shows the full set of flags.

// File: rtl/rx_alarm_pkg.sv
package rx_alarm_pkg;

  localparam int STAT_W = 8;
  localparam int LVL_W  = 6;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 8'h11;

  // Bit positions: order fixed by the processor's decoding of the register.
  localparam int BIT_CPERR = 7;
  localparam int BIT_LOS   = 6;
  localparam int BIT_AIS   = 5;
  localparam int BIT_IDLE  = 4;
  localparam int BIT_FERF  = 3;
  localparam int BIT_AIC   = 2;
  localparam int BIT_OOF   = 1;
  localparam int BIT_PERR  = 0;

  // Change pulse: any difference from the previous sample.
  function automatic logic [LVL_W-1:0] level_change(input logic [LVL_W-1:0] cur,
                                                    input logic [LVL_W-1:0] prev);
    return cur ^ prev;
  endfunction

  // Reset-on-read update of one flag; a set always wins over the clear.
  function automatic logic sticky_next(input logic q, input logic set, input logic clr);
    return (q & ~clr) | set;
  endfunction

  // Assemble the set vector in register bit order.
  function automatic logic [STAT_W-1:0] pack_sets(input logic cp,
                                                  input logic [LVL_W-1:0] chg,
                                                  input logic pb);
    return {cp, chg, pb};
  endfunction

  function automatic logic masked_any(input logic [STAT_W-1:0] q,
                                      input logic [STAT_W-1:0] en);
    return |(q & en);
  endfunction

endpackage

// File: rtl/alarm_change_detect.sv
module alarm_change_detect #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] chg
);
  import rx_alarm_pkg::*;

  logic [W-1:0] lvl_d;

  generate
    for (genvar i = 0; i < W; i++) begin : g_dly
      always_ff @(posedge clk) begin
        if (!rst_n) lvl_d[i] <= 1'b0;
        else        lvl_d[i] <= lvl[i];
      end
      assign chg[i] = lvl[i] ^ lvl_d[i];
    end
  endgenerate

endmodule

// File: rtl/alarm_sticky_bank.sv
module alarm_sticky_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr,
  output logic [W-1:0] q
);
  import rx_alarm_pkg::*;

  generate
    for (genvar i = 0; i < W; i++) begin : g_flag
      always_ff @(posedge clk) begin
        if (!rst_n) q[i] <= 1'b0;
        else        q[i] <= sticky_next(q[i], set_vec[i], clr);
      end
    end
  endgenerate

endmodule

// File: rtl/alarm_read_port.sv
module alarm_read_port #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] MY_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] status,
  output logic          rd_hit,
  output logic [DW-1:0] rd_data
);

  assign rd_hit = rd_en && (rd_addr == MY_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_hit) rd_data <= status;
    else             rd_data <= '0;
  end

endmodule

// File: rtl/rx_alarm_irq_reg.sv
module rx_alarm_irq_reg
  import rx_alarm_pkg::*;
#(
  parameter logic [ADDR_W-1:0] REG_ADDR = STAT_ADDR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpbit_err_pulse,
  input  logic              pbit_err_pulse,
  input  logic              los_lvl,
  input  logic              ais_lvl,
  input  logic              idle_lvl,
  input  logic              ferf_lvl,
  input  logic              aic_lvl,
  input  logic              oof_lvl,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [STAT_W-1:0] irq_mask,
  output logic [STAT_W-1:0] rd_data,
  output logic              irq
);

  // Named internal events, visible to the bound checker.
  logic [LVL_W-1:0]  lvl_vec;
  logic [LVL_W-1:0]  lvl_chg;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] status_q;
  logic              rd_hit;

  assign lvl_vec = {los_lvl, ais_lvl, idle_lvl, ferf_lvl, aic_lvl, oof_lvl};

  alarm_change_detect #(.W(LVL_W)) u_chg (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (lvl_vec),
    .chg   (lvl_chg)
  );

  assign set_vec = pack_sets(cpbit_err_pulse, lvl_chg, pbit_err_pulse);

  alarm_read_port #(.AW(ADDR_W), .DW(STAT_W), .MY_ADDR(REG_ADDR)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .status  (status_q),
    .rd_hit  (rd_hit),
    .rd_data (rd_data)
  );

  alarm_sticky_bank #(.W(STAT_W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr     (rd_hit),
    .q       (status_q)
  );

  assign irq = masked_any(status_q, irq_mask);

endmodule

// File: rtl/rx_alarm_irq_reg_chk.sv
module rx_alarm_irq_reg_chk
  import rx_alarm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rd_hit,
  input logic              rd_en,
  input logic [STAT_W-1:0] set_vec,
  input logic [STAT_W-1:0] status_q,
  input logic [STAT_W-1:0] irq_mask,
  input logic [STAT_W-1:0] rd_data,
  input logic              irq
);

  assert_reset_clear_R2: assert property (@(posedge clk)
    !rst_n |=> (status_q == '0 && rd_data == '0));

  assert_set_latches_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  assert_no_spurious_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(set_vec)) == '0));

  assert_read_returns_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> (rd_data == $past(status_q)));

  assert_read_keeps_new_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> (status_q == $past(set_vec)));

  assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> (rd_data == '0));

  assert_mask_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == '0 || status_q == '0) |-> !irq);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> ((status_q & $past(status_q)) == $past(status_q)));

  assert_hit_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> !rd_hit);

endmodule

bind rx_alarm_irq_reg rx_alarm_irq_reg_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_hit   (rd_hit),
  .rd_en    (rd_en),
  .set_vec  (set_vec),
  .status_q (status_q),
  .irq_mask (irq_mask),
  .rd_data  (rd_data),
  .irq      (irq)
);

// File: tb/rx_alarm_irq_reg_test.sv
module rx_alarm_irq_reg_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cp = 1'b0, pb = 1'b0;
  logic [5:0] lvl = 6'd0;   // {los, ais, idle, ferf, aic, oof}
  logic       rd_en = 1'b0;
  logic [7:0] rd_addr = 8'h00;
  logic [7:0] irq_mask = 8'hFF;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  rx_alarm_irq_reg uut (
    .clk (clk), .rst_n (rst_n),
    .cpbit_err_pulse (cp), .pbit_err_pulse (pb),
    .los_lvl (lvl[5]), .ais_lvl (lvl[4]), .idle_lvl (lvl[3]),
    .ferf_lvl (lvl[2]), .aic_lvl (lvl[1]), .oof_lvl (lvl[0]),
    .rd_en (rd_en), .rd_addr (rd_addr), .irq_mask (irq_mask),
    .rd_data (rd_data), .irq (irq)
  );

  // {cp, p, lvl[5:0], rd, addr[7:0], mask[7:0], exp_rd[7:0], exp_irq}
  localparam int NV = 16;
  localparam logic [33:0] VEC [NV] = '{
    {1'b0,1'b0,6'b000000,1'b1,8'h11,8'hFF,8'h00,1'b0}, // R1 empty read
    {1'b1,1'b0,6'b000000,1'b0,8'h00,8'hFF,8'h00,1'b1}, // R3 CP strobe
    {1'b0,1'b0,6'b000000,1'b1,8'h11,8'hFF,8'h80,1'b0}, // R1 R5 bit7
    {1'b0,1'b0,6'b100000,1'b0,8'h00,8'hFF,8'h00,1'b1}, // R4 LOS onset
    {1'b0,1'b0,6'b100000,1'b1,8'h11,8'hFF,8'h40,1'b0}, // R1 bit6
    {1'b0,1'b0,6'b100000,1'b0,8'h00,8'hFF,8'h00,1'b0}, // R9 steady level
    {1'b0,1'b0,6'b000000,1'b0,8'h00,8'hFF,8'h00,1'b1}, // R4 LOS end
    {1'b0,1'b0,6'b011000,1'b0,8'h00,8'hFF,8'h00,1'b1}, // R4 AIS+idle
    {1'b0,1'b0,6'b011000,1'b1,8'h11,8'hFF,8'h70,1'b0}, // R1 bits6..4
    {1'b0,1'b0,6'b000111,1'b0,8'h00,8'hFF,8'h00,1'b1}, // R4 five changes
    {1'b0,1'b1,6'b000111,1'b1,8'h12,8'h01,8'h00,1'b1}, // R7 miss, R3 P strobe
    {1'b0,1'b0,6'b000111,1'b0,8'h00,8'h80,8'h00,1'b0}, // R8 masked off
    {1'b0,1'b1,6'b000111,1'b1,8'h11,8'hFF,8'h3F,1'b1}, // R6 set during read
    {1'b0,1'b0,6'b000111,1'b1,8'h11,8'hFF,8'h01,1'b0}, // R6 kept bit0
    {1'b1,1'b0,6'b000000,1'b0,8'h00,8'h00,8'h00,1'b0}, // R8 mask 0
    {1'b0,1'b0,6'b000000,1'b1,8'h11,8'hFF,8'h8E,1'b0}  // R8 latching unaffected
  };

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic p, input logic [5:0] l,
                      input logic r, input logic [7:0] a, input logic [7:0] m);
    @(negedge clk);
    cp = c; pb = p; lvl = l; rd_en = r; rd_addr = a; irq_mask = m;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check8("R2 rd_data in reset", rd_data, 8'h00);
    check8("R2 irq in reset", {7'd0, irq}, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][33], VEC[i][32], VEC[i][31:26], VEC[i][25], VEC[i][24:17], VEC[i][16:9]);
      check8($sformatf("R1/R5 vec%0d rd_data", i), rd_data, VEC[i][8:1]);
      check8($sformatf("R8 vec%0d irq", i), {7'd0, irq}, {7'd0, VEC[i][0]});
    end

    // R6: level falling in the same cycle as the read that clears its onset
    step(1'b0, 1'b0, 6'b100000, 1'b0, 8'h00, 8'hFF);
    step(1'b0, 1'b0, 6'b000000, 1'b1, 8'h11, 8'hFF);
    check8("R6 read excludes new event", rd_data, 8'h40);
    check8("R6 irq after read", {7'd0, irq}, 8'h01);
    step(1'b0, 1'b0, 6'b000000, 1'b1, 8'h11, 8'hFF);
    check8("R6 event kept", rd_data, 8'h40);
    step(1'b0, 1'b0, 6'b000000, 1'b1, 8'h11, 8'hFF);
    check8("R5 cleared", rd_data, 8'h00);

    // R9: repeated strobes with no read, no drop over idle cycles
    step(1'b0, 1'b1, 6'b000000, 1'b0, 8'h00, 8'hFF);
    step(1'b0, 1'b1, 6'b000000, 1'b0, 8'h00, 8'hFF);
    for (int k = 0; k < 5; k++) step(1'b0, 1'b0, 6'b000000, 1'b0, 8'h00, 8'hFF);
    check8("R9 irq held", {7'd0, irq}, 8'h01);
    step(1'b0, 1'b0, 6'b000000, 1'b1, 8'h11, 8'hFF);
    check8("R9 flag held", rd_data, 8'h01);

    // R2: reset mid-run wipes a latched flag
    step(1'b1, 1'b0, 6'b000000, 1'b0, 8'h00, 8'hFF);
    @(negedge clk); rst_n = 1'b0; cp = 1'b0;
    @(posedge clk); #1;
    check8("R2 irq after reset", {7'd0, irq}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 1'b0, 6'b000000, 1'b1, 8'h11, 8'hFF);
    check8("R2 flags zero after reset", rd_data, 8'h00);

    // R4: level already high at reset release counts as onset
    @(negedge clk); rst_n = 1'b0; lvl = 6'b000010;
    @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 1'b0, 6'b000010, 1'b1, 8'h11, 8'hFF);
    check8("R4 onset at reset release", rd_data, 8'h04);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule